// File: doc/BRIEF.md
# Dual-Clock FIFO with Tunable Pointer Synchronisers

This block moves words from a producer running on one clock to a consumer running on another, unrelated clock. Each side owns its own pointer logic. The write pointer and the read pointer are kept in binary for addressing and in Gray code for crossing. Each Gray pointer reaches the far domain through a chain of flops. The length of each chain is set by its own parameter. The write side raises a full flag and the read side raises an empty flag. Each side also reports how many words are stored, as seen from its own clock. That count passes through a parameterised register delay before it leaves the block.

One shared clear input resets both sides. It takes effect at once. For each domain, a parameter picks how the clear is released. The release can be timed by that domain's clock, or the raw clear can drive that domain's flops directly. When the release is clocked, a request that arrives in the same cycle as the release cannot half-update a pointer. A related-clocks option cuts each crossing down to a single flop. It is meant for designs whose two clocks are derived from each other.

Top module: `dcf_fifo`

## Requirements
- R1: Immediately after the clear, `wr_full` is 0, `rd_empty` is 1, and both `wr_count` and `rd_count` are 0.
- R2: Words come out of `rd_data` in the order they were accepted, with none lost and none repeated, whatever the ratio of the two clock frequencies.
- R3: A write request made while `wr_full` is 1 is dropped. The stored contents and the write pointer do not change, and the dropped word is never read out.
- R4: A read request made while `rd_empty` is 1 is ignored. `rd_data` keeps its value, and the next word written is the next word read.
- R5: `wr_full` becomes 1 on the write-clock edge that accepts the 2^ADDR_W-th stored word, and not before.
- R6: `rd_empty` becomes 1 on the read-clock edge that accepts the read of the last stored word.
- R7: When CNT_EXTRA_BIT is 1, the counts are ADDR_W+1 bits wide and a full FIFO reports 2^ADDR_W. When it is 0, the counts are ADDR_W bits wide and a full FIFO reports 0.
- R8: An accepted write shows up in `wr_count` on the CNT_DELAY-th write-clock edge after the edge that accepted it. The value does not change on any earlier edge.
- R9: Each crossing uses PIPE-2 flops, with at least one, where PIPE is WR2RD_PIPE or RD2WR_PIPE. It uses one flop when CLOCKS_RELATED is 1. After a write into an empty FIFO, `rd_empty` falls between the (stages+1)-th and (stages+2)-th read-clock edge. The Gray pointers change by at most one bit per clock.
- R10: Raising `clr` resets flags and counts at once, without waiting for a clock edge.
- R11: When the clear release is clocked into a domain, requests on the first two edges of that domain's clock after `clr` falls are dropped. Requests from the third edge on are served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clr | input | 1 | Shared clear, active high, acts without a clock |
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No free slot, seen from the write side |
| wr_count | output | ADDR_W+CNT_EXTRA_BIT | Stored words as seen by the write side, delayed by CNT_DELAY |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Word read, registered, updated on an accepted read |
| rd_empty | output | 1 | Nothing stored, seen from the read side |
| rd_count | output | ADDR_W+CNT_EXTRA_BIT | Stored words as seen by the read side, delayed by CNT_DELAY |

## Verification
The risky coincidence is a write and a read landing around the same moment while the FIFO sits at a boundary. One case is a write arriving while a read is freeing the last slot. The other is a read taking the last word while a new write is still crossing. The bench provokes both by streaming long runs. One run has the slower reader, so the FIFO hovers at full. Another has gaps on the writer, so it hovers at empty. The clock ratio is 1.4, so edges drift against each other. Every word is judged against a scoreboard of the expected sequence. The bench then checks that both sides settle to an empty FIFO with zero counts.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    // Crossing depth: the parameter carries two extra counts; related clocks use one flop.
    function automatic int sync_depth(input int pipe, input int related);
        int n;
        if (related != 0) begin
            n = 1;
        end else begin
            n = pipe - 2;
            if (n < 1) n = 1;
        end
        return n;
    endfunction

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync #(
    parameter int ENABLE = 1
) (
    input  logic clk,
    input  logic clr,
    output logic rst
);
    generate
        if (ENABLE != 0) begin : g_sync
            logic [1:0] stg;
            always_ff @(posedge clk or posedge clr) begin
                if (clr) stg <= 2'b11;
                else     stg <= {stg[0], 1'b0};
            end
            assign rst = stg[1];
        end else begin : g_direct
            assign rst = clr;
        end
    endgenerate
endmodule

// File: rtl/dcf_sync_chain.sv
module dcf_sync_chain #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or posedge rst) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or posedge rst) begin
                    if (rst) stg[i] <= '0;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CW        = 5,
    parameter int CNT_DELAY = 1,
    localparam int PW       = ADDR_W + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] rgray_s,
    output logic          we,
    output logic [PW-1:0] wbin,
    output logic [PW-1:0] wgray,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [PW-1:0] wbin_nxt, wgray_nxt, rbin_s, diff, full_pat;
    logic          full_nxt;
    logic [CW-1:0] cnt_pipe [CNT_DELAY];

    assign we        = wr_en && !full;
    assign wbin_nxt  = wbin + PW'(we);
    assign wgray_nxt = PW'(bin2gray(32'(wbin_nxt)));
    assign full_pat  = {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]};
    assign full_nxt  = (wgray_nxt == full_pat);
    assign rbin_s    = PW'(gray2bin(32'(rgray_s)));
    assign diff      = wbin - rbin_s;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            wbin  <= '0;
            wgray <= '0;
            full  <= 1'b0;
        end else begin
            wbin  <= wbin_nxt;
            wgray <= wgray_nxt;
            full  <= full_nxt;
        end
    end

    generate
        for (genvar i = 0; i < CNT_DELAY; i++) begin : g_cnt
            always_ff @(posedge clk or posedge rst) begin
                if (rst)         cnt_pipe[i] <= '0;
                else if (i == 0) cnt_pipe[i] <= diff[CW-1:0];
                else             cnt_pipe[i] <= cnt_pipe[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign count = cnt_pipe[CNT_DELAY-1];
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
    import dcf_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CW        = 5,
    parameter int CNT_DELAY = 1,
    localparam int PW       = ADDR_W + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [PW-1:0] wgray_s,
    output logic          re,
    output logic [PW-1:0] rbin,
    output logic [PW-1:0] rgray,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [PW-1:0] rbin_nxt, rgray_nxt, wbin_s, diff;
    logic          empty_nxt;
    logic [CW-1:0] cnt_pipe [CNT_DELAY];

    assign re        = rd_en && !empty;
    assign rbin_nxt  = rbin + PW'(re);
    assign rgray_nxt = PW'(bin2gray(32'(rbin_nxt)));
    assign empty_nxt = (rgray_nxt == wgray_s);
    assign wbin_s    = PW'(gray2bin(32'(wgray_s)));
    assign diff      = wbin_s - rbin;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            rbin  <= '0;
            rgray <= '0;
            empty <= 1'b1;
        end else begin
            rbin  <= rbin_nxt;
            rgray <= rgray_nxt;
            empty <= empty_nxt;
        end
    end

    generate
        for (genvar i = 0; i < CNT_DELAY; i++) begin : g_cnt
            always_ff @(posedge clk or posedge rst) begin
                if (rst)         cnt_pipe[i] <= '0;
                else if (i == 0) cnt_pipe[i] <= diff[CW-1:0];
                else             cnt_pipe[i] <= cnt_pipe[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign count = cnt_pipe[CNT_DELAY-1];
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
    import dcf_pkg::*;
#(
    parameter int DATA_W         = 8,
    parameter int ADDR_W         = 4,
    parameter int WR2RD_PIPE     = 4,
    parameter int RD2WR_PIPE     = 4,
    parameter int CLOCKS_RELATED = 0,
    parameter int CNT_DELAY      = 1,
    parameter int CNT_EXTRA_BIT  = 1,
    parameter int CLR_SYNC_WR    = 1,
    parameter int CLR_SYNC_RD    = 1,
    localparam int DEPTH         = 1 << ADDR_W,
    localparam int PW            = ADDR_W + 1,
    localparam int CW            = ADDR_W + ((CNT_EXTRA_BIT != 0) ? 1 : 0),
    localparam int NS_W2R        = sync_depth(WR2RD_PIPE, CLOCKS_RELATED),
    localparam int NS_R2W        = sync_depth(RD2WR_PIPE, CLOCKS_RELATED)
) (
    input  logic              clr,
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic [CW-1:0]     wr_count,
    input  logic              rd_clk,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic [CW-1:0]     rd_count
);
    logic          wr_rst, rd_rst;
    logic          wr_we, rd_re;
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] wgray_s, rgray_s;
    logic [DATA_W-1:0] mem [DEPTH];

    dcf_rst_sync #(.ENABLE(CLR_SYNC_WR)) u_wr_rst (
        .clk(wr_clk), .clr(clr), .rst(wr_rst)
    );
    dcf_rst_sync #(.ENABLE(CLR_SYNC_RD)) u_rd_rst (
        .clk(rd_clk), .clr(clr), .rst(rd_rst)
    );

    dcf_sync_chain #(.W(PW), .STAGES(NS_W2R)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s)
    );
    dcf_sync_chain #(.W(PW), .STAGES(NS_R2W)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s)
    );

    dcf_wr_ctrl #(.ADDR_W(ADDR_W), .CW(CW), .CNT_DELAY(CNT_DELAY)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .wr_en(wr_en), .rgray_s(rgray_s),
        .we(wr_we), .wbin(wbin), .wgray(wgray), .full(wr_full), .count(wr_count)
    );
    dcf_rd_ctrl #(.ADDR_W(ADDR_W), .CW(CW), .CNT_DELAY(CNT_DELAY)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en), .wgray_s(wgray_s),
        .re(rd_re), .rbin(rbin), .rgray(rgray), .empty(rd_empty), .count(rd_count)
    );

    always_ff @(posedge wr_clk) begin
        if (wr_we) mem[wbin[ADDR_W-1:0]] <= wr_data;
    end

    always_ff @(posedge rd_clk or posedge rd_rst) begin
        if (rd_rst)     rd_data <= '0;
        else if (rd_re) rd_data <= mem[rbin[ADDR_W-1:0]];
    end
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
    parameter int PW     = 5,
    parameter int DATA_W = 8
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              wr_rst,
    input logic              rd_rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic              wr_full,
    input logic              rd_empty,
    input logic [PW-1:0]     wbin,
    input logic [PW-1:0]     rbin,
    input logic [PW-1:0]     wgray,
    input logic [PW-1:0]     rgray,
    input logic [DATA_W-1:0] rd_data
);
    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_full && wr_en) |=> $stable(wbin)); // R3

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_empty && rd_en) |=> ($stable(rbin) && $stable(rd_data))); // R4

    AST_WR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wgray ^ $past(wgray)) <= 1); // R9

    AST_RD_GRAY_STEP: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $countones(rgray ^ $past(rgray)) <= 1); // R9
endmodule

bind dcf_fifo dcf_fifo_chk #(.PW(ADDR_W + 1), .DATA_W(DATA_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst(wr_rst), .rd_rst(rd_rst),
    .wr_en(wr_en), .rd_en(rd_en), .wr_full(wr_full), .rd_empty(rd_empty),
    .wbin(wbin), .rbin(rbin), .wgray(wgray), .rgray(rgray), .rd_data(rd_data)
);

// File: tb/dcf_fifo_bench.sv
module dcf_fifo_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = 14;
    localparam int DEPTH      = 16;

    logic       clr = 1'b1;
    logic       wr_clk = 1'b0, rd_clk = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;

    logic       wr_full, rd_empty, a_wr_full, a_rd_empty;
    logic [4:0] wr_count, rd_count;
    logic [3:0] a_wr_count, a_rd_count;
    logic [7:0] rd_data, a_rd_data;

    int n_chk = 0, n_fail = 0, base = 0;

    always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

    dcf_fifo u_dcf_fifo (
        .clr(clr), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .wr_count(wr_count), .rd_clk(rd_clk), .rd_en(rd_en),
        .rd_data(rd_data), .rd_empty(rd_empty), .rd_count(rd_count)
    );

    // Variant: single-flop crossings, narrow counts, three-cycle count delay.
    dcf_fifo #(.CLOCKS_RELATED(1), .CNT_DELAY(3), .CNT_EXTRA_BIT(0)) u_dcf_fifo_alt (
        .clr(clr), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(a_wr_full), .wr_count(a_wr_count), .rd_clk(rd_clk), .rd_en(rd_en),
        .rd_data(a_rd_data), .rd_empty(a_rd_empty), .rd_count(a_rd_count)
    );

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic do_clear();
        wr_en = 1'b0; rd_en = 1'b0; clr = 1'b1;
        repeat (3) @(posedge rd_clk);
        @(negedge wr_clk);
        clr = 1'b0;
        repeat (4) @(negedge wr_clk);
        repeat (4) @(negedge rd_clk);
    endtask

    task automatic t_reset();
        do_clear();
        chk_eq("R1 wr_full", int'(wr_full), 0);
        chk_eq("R1 rd_empty", int'(rd_empty), 1);
        chk_eq("R1 wr_count", int'(wr_count), 0);
        chk_eq("R1 rd_count", int'(rd_count), 0);
        chk_eq("R1 alt rd_empty", int'(a_rd_empty), 1);
    endtask

    task automatic t_count_latency();
        do_clear();
        @(negedge wr_clk); wr_en = 1'b1; wr_data = 8'h31;
        @(negedge wr_clk); wr_en = 1'b0;
        chk_eq("R8 count at accept edge", int'(wr_count), 0);
        chk_eq("R8 alt count at accept edge", int'(a_wr_count), 0);
        @(negedge wr_clk);
        chk_eq("R8 count one edge later", int'(wr_count), 1);
        chk_eq("R8 alt count one edge later", int'(a_wr_count), 0);
        @(negedge wr_clk);
        chk_eq("R8 alt count two edges later", int'(a_wr_count), 0);
        @(negedge wr_clk);
        chk_eq("R8 alt count three edges later", int'(a_wr_count), 1);
    endtask

    task automatic t_sync_latency();
        int n_main = 0, n_alt = 0;
        do_clear();
        @(negedge wr_clk); wr_en = 1'b1; wr_data = 8'h42;
        @(posedge wr_clk); #1; wr_en = 1'b0;
        fork
            begin
                while (rd_empty && n_main < 20) begin @(posedge rd_clk); #1; n_main++; end
            end
            begin
                while (a_rd_empty && n_alt < 20) begin @(posedge rd_clk); #1; n_alt++; end
            end
        join
        chk_rng("R9 empty release, two stages", n_main, 3, 4);
        chk_rng("R9 empty release, related clocks", n_alt, 2, 3);
    endtask

    task automatic t_fill_drain();
        do_clear();
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge wr_clk);
            if (i == DEPTH - 1) chk_eq("R5 not full one word early", int'(wr_full), 0);
            wr_en = 1'b1; wr_data = pat(100 + i);
        end
        @(negedge wr_clk);
        chk_eq("R5 full on last accept", int'(wr_full), 1);
        wr_data = 8'hEE;                         // extra write while full
        @(negedge wr_clk); wr_en = 1'b0;
        chk_eq("R3 still full after dropped write", int'(wr_full), 1);
        repeat (3) @(negedge wr_clk);
        chk_eq("R7 wide count shows depth", int'(wr_count), DEPTH);
        chk_eq("R7 narrow count wraps to zero", int'(a_wr_count), 0);
        chk_eq("R7 narrow side full", int'(a_wr_full), 1);
        repeat (6) @(negedge rd_clk);
        chk_eq("R7 read side count shows depth", int'(rd_count), DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            rd_en = 1'b1;
            @(negedge rd_clk);
            chk_eq("R2 drain order", int'(rd_data), int'(pat(100 + i)));
        end
        chk_eq("R6 empty on last read", int'(rd_empty), 1);
        // Reads while empty must not move anything.
        repeat (4) @(negedge rd_clk);
        rd_en = 1'b0;
        chk_eq("R4 data held on empty read", int'(rd_data), int'(pat(100 + DEPTH - 1)));
        chk_eq("R3 dropped word absent", int'(rd_empty), 1);
        @(negedge wr_clk); wr_en = 1'b1; wr_data = 8'h77;
        @(negedge wr_clk); wr_en = 1'b0;
        while (rd_empty) @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk); rd_en = 1'b0;
        chk_eq("R4 next written word is next read", int'(rd_data), 8'h77);
        repeat (6) @(negedge rd_clk);
        chk_eq("R7 read count back to zero", int'(rd_count), 0);
    endtask

    task automatic t_stream(input int n, input int wr_gap, input int rd_gap);
        int b0 = base;
        base += n;
        fork
            begin
                @(negedge wr_clk);
                for (int i = 0; i < n; i++) begin
                    while (wr_full) begin wr_en = 1'b0; @(negedge wr_clk); end
                    wr_en = 1'b1; wr_data = pat(b0 + i);
                    @(negedge wr_clk);
                    if (wr_gap > 0) begin wr_en = 1'b0; repeat (wr_gap) @(negedge wr_clk); end
                end
                wr_en = 1'b0;
            end
            begin
                @(negedge rd_clk);
                for (int j = 0; j < n; j++) begin
                    while (rd_empty) begin rd_en = 1'b0; @(negedge rd_clk); end
                    rd_en = 1'b1;
                    @(negedge rd_clk);
                    chk_eq("R2 stream order", int'(rd_data), int'(pat(b0 + j)));
                    if (rd_gap > 0) begin rd_en = 1'b0; repeat (rd_gap) @(negedge rd_clk); end
                end
                rd_en = 1'b0;
            end
        join
        repeat (8) @(negedge rd_clk);
        @(negedge wr_clk);
        chk_eq("R2 stream leaves empty", int'(rd_empty), 1);
        chk_eq("R2 stream write count zero", int'(wr_count), 0);
        chk_eq("R2 stream read count zero", int'(rd_count), 0);
    endtask

    task automatic t_clear_async();
        do_clear();
        for (int i = 0; i < 3; i++) begin
            @(negedge wr_clk); wr_en = 1'b1; wr_data = pat(i);
        end
        @(negedge wr_clk); wr_en = 1'b0;
        repeat (6) @(negedge rd_clk);
        chk_eq("R10 data present before clear", int'(rd_count), 3);
        #2; clr = 1'b1; #1;
        chk_eq("R10 rd_empty at once", int'(rd_empty), 1);
        chk_eq("R10 wr_count at once", int'(wr_count), 0);
        chk_eq("R10 rd_count at once", int'(rd_count), 0);
        chk_eq("R10 wr_full at once", int'(wr_full), 0);
        do_clear();
    endtask

    task automatic t_clear_race();
        wr_en = 1'b0; rd_en = 1'b0; clr = 1'b1;
        repeat (3) @(posedge rd_clk);
        @(negedge wr_clk);
        clr = 1'b0; wr_en = 1'b1; wr_data = 8'hC3;   // held for edges 1 and 2
        repeat (2) @(negedge wr_clk);
        wr_en = 1'b0;
        repeat (10) @(negedge wr_clk);
        repeat (8) @(negedge rd_clk);
        chk_eq("R11 write at release dropped", int'(wr_count), 0);
        chk_eq("R11 alt write at release dropped", int'(a_wr_count), 0);
        chk_eq("R11 read side still empty", int'(rd_empty), 1);
        @(negedge wr_clk); wr_en = 1'b1; wr_data = 8'h5C;
        @(negedge wr_clk); wr_en = 1'b0;
        while (rd_empty) @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk); rd_en = 1'b0;
        chk_eq("R11 later write served", int'(rd_data), 8'h5C);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_count_latency();
        t_sync_latency();
        t_fill_drain();
        t_stream(150, 0, 0);
        t_stream(150, 3, 0);
        t_stream(100, 0, 2);
        t_clear_async();
        t_clear_race();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule